// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of physical register indices that a rename stage can hand to new instructions. It is a ring buffer. A head pointer marks the next index to give out, and a tail pointer marks where returned indices are written. Both pointers carry a wrap bit, so the number of free entries is simply their difference. Each cycle, a group of rename lanes may each ask for one index. The list offers an index to every asking lane at once, but it consumes them only when an outside controller confirms the whole group.

Retiring instructions return the physical registers they displaced, one per commit slot. When a misprediction is undone by walking back through squashed instructions, the controller tells the list how many destinations that cycle's walk covered. The head then steps back by that amount, so those indices become free again in their original order. A flush makes every index that is not part of the committed mapping free at once.

After reset, the list holds every physical index above the logical register count, in ascending order. The lower indices are left for the identity mapping of the logical registers.

Top module: `phys_free_list`

## Requirements
- R1: After reset, the list holds indices NUM_LOG through NUM_PHYS-1 in ascending order, and `can_alloc` is 1. With every lane requesting, lane 0 is offered NUM_LOG, lane 1 NUM_LOG+1, and so on.
- R2: `can_alloc` is 1 exactly when the free count is at least LANES. While it is 0, asserting `do_alloc` consumes nothing.
- R3: A requesting lane i is offered the entry at position head plus the number of requesting lanes below i. Lane i's offer sits in bits [i*PW +: PW] of `alloc_idx`. The head advances by the number of requesting lanes only when `do_alloc` and `can_alloc` are both 1 and none of `walk`, `redirect` or `flush` is 1.
- R4: With `do_alloc` at 0, the head holds, and the same indices are offered again in the next cycle.
- R5: While `walk` is 1, no allocation takes effect, even when `do_alloc` is 1.
- R6: While `walk` is 1 and `flush` is 0, the head moves back by `step_back`. The indices it uncovers are offered again in the order in which they were first handed out.
- R7: Each `free_req` slot that is set, with `walk` at 0, appends its `free_idx` value at the tail, in ascending slot order. Slot j's value sits in bits [j*PW +: PW] of `free_idx`. Up to COMMIT values are appended per cycle. The free count never exceeds NUM_PHYS-NUM_LOG.
- R8: Free requests made while `walk` is 1 are ignored, and the tail does not move.
- R9: While `redirect` is 1, no allocation takes effect.
- R10: `flush` overrides walk and allocation. One cycle later, all NUM_PHYS-NUM_LOG entries are free. Frees made in the flush cycle are kept, and the oldest free entry is the one that lies NUM_PHYS-NUM_LOG positions behind the new tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | LANES | Per-lane request for a physical index |
| alloc_idx | output | LANES*PW | Per-lane offered index, lane i in bits [i*PW +: PW] |
| can_alloc | output | 1 | Free count covers a full lane group |
| do_alloc | input | 1 | External confirmation that the group may take its indices |
| free_req | input | COMMIT | Per-commit-slot return request |
| free_idx | input | COMMIT*PW | Per-slot returned index, slot j in bits [j*PW +: PW] |
| walk | input | 1 | Recovery walk in progress |
| step_back | input | $clog2(COMMIT+1) | Number of walked destinations this cycle |
| redirect | input | 1 | Squash in progress; blocks allocation |
| flush | input | 1 | Return every speculative index to the list |

## Verification
The bound checks assume a legal controller. Frees never push the free count past NUM_PHYS-NUM_LOG. During a walk, `step_back` never exceeds either the number of indices handed out since the last flush or the room left in the list. The stimulus honours both limits: its reference model tracks the free queue and the allocation history, and it caps each free burst and each walk step by those sizes. Outside these bounds a pointer could wrap past the other, and the bound-on-count property would no longer be meaningful.

// File: rtl/phys_free_list.sv
module phys_free_list #(
  parameter int LANES    = 4,
  parameter int COMMIT   = 4,
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 32,
  localparam int PW  = $clog2(NUM_PHYS),
  localparam int SBW = $clog2(COMMIT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      alloc_req,
  output logic [LANES*PW-1:0]   alloc_idx,
  output logic                  can_alloc,
  input  logic                  do_alloc,
  input  logic [COMMIT-1:0]     free_req,
  input  logic [COMMIT*PW-1:0]  free_idx,
  input  logic                  walk,
  input  logic [SBW-1:0]        step_back,
  input  logic                  redirect,
  input  logic                  flush
);
  localparam int DEPTH = NUM_PHYS - NUM_LOG;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(LANES + 1);
  localparam int FW    = $clog2(COMMIT + 1);

  logic [PW-1:0] ring [DEPTH];
  logic [AW:0]   head, tail, count, tail_nx;
  logic [CW-1:0] a_off [LANES];
  logic [CW-1:0] a_tot;
  logic [FW-1:0] f_off [COMMIT];
  logic [FW-1:0] f_tot;
  logic [COMMIT-1:0] free_go;
  logic fire;

  assign count     = tail - head;
  assign can_alloc = count >= (AW+1)'(LANES);
  assign fire      = do_alloc && can_alloc && !walk && !redirect && !flush;
  assign free_go   = free_req & {COMMIT{!walk}};
  assign tail_nx   = tail + (AW+1)'(f_tot);

  always_comb begin
    a_tot = '0;
    for (int i = 0; i < LANES; i++) begin
      a_off[i] = a_tot;
      a_tot    = a_tot + CW'(alloc_req[i]);
    end
  end

  always_comb begin
    f_tot = '0;
    for (int j = 0; j < COMMIT; j++) begin
      f_off[j] = f_tot;
      f_tot    = f_tot + FW'(free_go[j]);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] slot;
    assign slot = head[AW-1:0] + AW'(a_off[i]);
    assign alloc_idx[i*PW +: PW] = ring[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ring[k] <= PW'(NUM_LOG + k);
      head <= '0;
      tail <= {1'b1, {AW{1'b0}}};
    end else begin
      for (int j = 0; j < COMMIT; j++)
        if (free_go[j]) ring[tail[AW-1:0] + AW'(f_off[j])] <= free_idx[j*PW +: PW];
      tail <= tail_nx;
      if (flush)     head <= tail_nx ^ {1'b1, {AW{1'b0}}};
      else if (walk) head <= head - (AW+1)'(step_back);
      else if (fire) head <= head + (AW+1)'(a_tot);
    end
  end
endmodule

module phys_free_list_chk #(
  parameter int LANES    = 4,
  parameter int COMMIT   = 4,
  parameter int NUM_PHYS = 64,
  parameter int NUM_LOG  = 32,
  localparam int DEPTH = NUM_PHYS - NUM_LOG,
  localparam int AW    = $clog2(DEPTH),
  localparam int SBW   = $clog2(COMMIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] alloc_req,
  input logic             do_alloc,
  input logic             can_alloc,
  input logic             walk,
  input logic [SBW-1:0]   step_back,
  input logic             redirect,
  input logic             flush,
  input logic [AW:0]      head,
  input logic [AW:0]      tail
);
  logic [AW:0] cnt;
  logic        go;
  assign cnt = tail - head;
  assign go  = do_alloc && can_alloc && !walk && !redirect && !flush;

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= (AW+1)'(DEPTH));
  // R10
  flush_full_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> cnt == (AW+1)'(DEPTH));
  // R6
  walk_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk && !flush |=> head == (AW+1)'($past(head) - (AW+1)'($past(step_back))));
  // R3
  alloc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> head == (AW+1)'($past(head) + (AW+1)'($countones($past(alloc_req)))));
  // R4
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_alloc && !walk && !flush |=> $stable(head));
  // R8
  walk_tail_chk: assert property (@(posedge clk) disable iff (!rst_n) walk |=> $stable(tail));
  // R9
  redirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && !walk && !flush |=> $stable(head));
endmodule

bind phys_free_list phys_free_list_chk #(
  .LANES(LANES), .COMMIT(COMMIT), .NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .do_alloc(do_alloc),
  .can_alloc(can_alloc), .walk(walk), .step_back(step_back), .redirect(redirect),
  .flush(flush), .head(head), .tail(tail)
);

// File: tb/sim_phys_free_list.sv
module sim_phys_free_list;
  localparam int LANES = 4, COMMIT = 4, NUM_PHYS = 64, NUM_LOG = 32;
  localparam int PW = $clog2(NUM_PHYS), SBW = $clog2(COMMIT + 1);
  localparam int DEPTH = NUM_PHYS - NUM_LOG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LANES-1:0]     alloc_req = '0;
  logic [LANES*PW-1:0]  alloc_idx;
  logic                 can_alloc;
  logic                 do_alloc = 1'b0;
  logic [COMMIT-1:0]    free_req = '0;
  logic [COMMIT*PW-1:0] free_idx = '0;
  logic                 walk = 1'b0;
  logic [SBW-1:0]       step_back = '0;
  logic                 redirect = 1'b0, flush = 1'b0;

  phys_free_list u0 (.*);

  always #10 clk = ~clk;

  typedef struct { int lane; int val; string tag; } item_t;
  item_t exp_q[$];
  int q[$], hist[$];
  int checks = 0, fails = 0, fv = 5;
  bit done = 0;

  task automatic cyc(input logic [LANES-1:0] req, input bit da, input int nfree,
                     input bit wk, input int sb, input bit rd, input bit fl, input string tag);
    int off, n;
    int fvals[$];
    bit can, go;
    @(negedge clk);
    alloc_req = req; do_alloc = da; walk = wk; step_back = SBW'(sb);
    redirect = rd; flush = fl;
    free_req = '0; free_idx = '0;
    for (int j = 0; j < nfree; j++) begin
      fv = (fv + 13) % NUM_PHYS;
      free_req[j] = 1'b1;
      free_idx[j*PW +: PW] = PW'(fv);
      fvals.push_back(fv);
    end
    can = q.size() >= LANES;
    exp_q.push_back('{-1, int'(can), tag});
    off = 0;
    for (int i = 0; i < LANES; i++)
      if (req[i]) begin
        if (off < q.size()) exp_q.push_back('{i, q[off], tag});
        off++;
      end
    go = da && can && !wk && !rd && !fl;
    if (!wk) foreach (fvals[k]) q.push_back(fvals[k]);
    if (fl) begin
      n = DEPTH - q.size();
      for (int k = 0; k < n; k++) q.push_front(hist.pop_back());
    end else if (wk) begin
      for (int k = 0; k < sb; k++) q.push_front(hist.pop_back());
    end else if (go) begin
      for (int k = 0; k < off; k++) hist.push_back(q.pop_front());
    end
  endtask

  initial forever begin
    @(negedge clk);
    #5;
    while (exp_q.size() > 0) begin
      item_t it;
      int got;
      it = exp_q.pop_front();
      got = (it.lane < 0) ? int'(can_alloc) : int'(alloc_idx[it.lane*PW +: PW]);
      checks++;
      if (got != it.val) begin
        fails++;
        $display("FAIL %s lane %0d: actual %0d expected %0d", it.tag, it.lane, got, it.val);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) q.push_back(NUM_LOG + k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(4'b1111, 1, 0, 0, 0, 0, 0, "R1");
    cyc(4'b1010, 1, 0, 0, 0, 0, 0, "R3");
    cyc(4'b0110, 0, 0, 0, 0, 0, 0, "R4");
    cyc(4'b0110, 1, 0, 0, 0, 0, 0, "R4");
    cyc(4'b1111, 1, 0, 1, 3, 0, 0, "R5");
    cyc(4'b1111, 0, 0, 0, 0, 0, 0, "R6");
    cyc(4'b1111, 1, 0, 0, 0, 1, 0, "R9");
    cyc(4'b1111, 0, 0, 0, 0, 0, 0, "R9");
    while (q.size() >= LANES) cyc(4'b1111, 1, 0, 0, 0, 0, 0, "R2");
    cyc(4'b0011, 1, 0, 0, 0, 0, 0, "R2");
    cyc(4'b0011, 1, 0, 0, 0, 0, 0, "R2");
    cyc(4'b0000, 0, 3, 0, 0, 0, 0, "R7");
    cyc(4'b1111, 0, 2, 1, 0, 0, 0, "R8");
    cyc(4'b1111, 0, 2, 0, 0, 0, 0, "R8");
    cyc(4'b1111, 1, 0, 0, 0, 0, 0, "R7");
    cyc(4'b1111, 1, 2, 1, 2, 0, 1, "R10");
    cyc(4'b1111, 0, 0, 0, 0, 0, 0, "R10");
    for (int r = 0; r < 400; r++) begin
      int nf, sb, mx;
      bit wk;
      wk = ($urandom % 6) == 0;
      mx = DEPTH - q.size();
      nf = $urandom % (COMMIT + 1);
      if (nf > mx) nf = mx;
      sb = 0;
      if (wk) begin
        sb = $urandom % (COMMIT + 1);
        if (sb > hist.size()) sb = hist.size();
        if (sb > mx) sb = mx;
        nf = 0;
      end
      cyc(LANES'($urandom), ($urandom % 4) != 0, nf, wk, sb,
          ($urandom % 10) == 0, ($urandom % 50) == 0, "R3");
    end
    cyc(4'b0000, 0, 0, 0, 0, 0, 0, "R3");
    @(negedge clk);
    #8;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule